// File: doc/BRIEF.md
# Qualified Interrupt Register with Halt Aggregation

This block keeps a row of one-bit event flags in flip-flops and folds them into two summary lines for a host or debug controller. A hardware event input sets a flag. Software clears a flag by writing a one to its position. Each flag is fixed at elaboration time as either an interrupt field or a plain status bit.

Every interrupt field has two independent gating choices. The first one selects how the field reaches the interrupt line: through an inverted gate (mask), through a true gate (enable), or directly. The second one selects how the field reaches the halt line: through an inverted halt gate, through a true halt gate, or directly. Both summary lines are combinational ORs of the gated fields and have no register stage. The halt line is active only when at least one interrupt field has a halt gate configured; otherwise it is tied low.

The block has no state machine. Its only sequential state is the flag row. Each flag moves between two named conditions, CLEAR and PENDING. Transition SET goes to PENDING on an event. Transition ACK goes from PENDING to CLEAR on a software write of one with no event present. Reset forces CLEAR.

Top module: `intreg_halt_agg`

## Requirements
- R1: While `rst_n` is low, every flag is 0 and both `intr_o` and `halt_o` are 0. The reset is asynchronous.
- R2: A flag whose `evt_i` bit is high at a rising clock edge reads 1 on `field_q_o` after that edge. A flag with no event and no clear keeps its value.
- R3: When `clr_we_i` is 1 at an edge, each flag whose `clr_data_i` bit is 1 becomes 0, and flags whose data bit is 0 keep their value. When `clr_we_i` is 0, `clr_data_i` has no effect.
- R4: An event and a clear on the same flag at the same edge leave the flag at 1.
- R5: An interrupt field with qualifier code 2'b01 (mask) at `QUAL_CFG[2i+1:2i]` contributes its flag ANDed with the inverse of `mask_i[i]`.
- R6: An interrupt field with qualifier code 2'b10 (enable) contributes its flag ANDed with `enable_i[i]`.
- R7: An interrupt field with qualifier code 2'b00 contributes its raw flag to `intr_o`, whatever the gate inputs are. The reserved code 2'b11 behaves the same way.
- R8: `intr_o` equals the OR of all interrupt-field contributions. It follows the flags and gates in the same cycle.
- R9: When halt is active, an interrupt field with halt code 2'b01 at `HALT_CFG[2i+1:2i]` contributes its flag ANDed with the inverse of `hmask_i[i]`. A field with halt code 2'b10 contributes its flag ANDed with `henable_i[i]`. `halt_o` is the OR of all halt contributions.
- R10: When halt is active, an interrupt field with halt code 2'b00 contributes its raw flag to `halt_o`.
- R11: A field whose `INTR_MAP` bit is 0 stores and shows its flag but contributes to neither `intr_o` nor `halt_o`, whatever its gate inputs are.
- R12: When no interrupt field has halt code 2'b01 or 2'b10, `halt_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_FIELDS | Per-flag hardware set request |
| clr_we_i | input | 1 | Software clear write strobe |
| clr_data_i | input | N_FIELDS | Write-one-to-clear data |
| mask_i | input | N_FIELDS | Inverted interrupt gates |
| enable_i | input | N_FIELDS | True interrupt gates |
| hmask_i | input | N_FIELDS | Inverted halt gates |
| henable_i | input | N_FIELDS | True halt gates |
| field_q_o | output | N_FIELDS | Stored flag row |
| intr_o | output | 1 | Register-level interrupt |
| halt_o | output | 1 | Register-level halt request |

## Verification
Three flag-level properties are checked on every cycle: SET wins over ACK, ACK clears, and a flag with neither input holds its value. The checks also confirm that neither summary line is raised while no interrupt-field flag is pending. How each gate polarity selects a field, how a halt-ungated field reaches the halt line, and how a status bit is kept out of both lines depend on the elaboration settings. These can only be shown by bench scenarios that toggle each gate around a single pending flag. The bench also uses a second instance that has no halt gates.

// File: rtl/intreg_pkg.sv
`timescale 1ns/1ps
package intreg_pkg;

    // Two-bit gating code used for both the interrupt and the halt path.
    typedef enum logic [1:0] {
        QK_DIRECT = 2'b00,
        QK_INVERT = 2'b01,
        QK_TRUE   = 2'b10,
        QK_RSVD   = 2'b11
    } qual_kind_e;

    // Flag condition names (documentation of the two-state flag).
    typedef enum logic {
        FLAG_CLEAR   = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

endpackage

// File: rtl/intreg_field_bit.sv
`timescale 1ns/1ps
module intreg_field_bit
    import intreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    flag_state_e state_q, state_d;

    // Next-state process: SET dominates ACK.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR:   if (set_i) state_d = FLAG_PENDING;
            FLAG_PENDING: if (clr_i && !set_i) state_d = FLAG_CLEAR;
            default:      state_d = FLAG_CLEAR;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    // Output process.
    always_comb q_o = (state_q == FLAG_PENDING);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o); // R4

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(q_o)); // R2

endmodule

// File: rtl/intreg_or_agg.sv
`timescale 1ns/1ps
module intreg_or_agg
    import intreg_pkg::*;
#(
    parameter int                      N_FIELDS = 10,
    parameter logic [2*N_FIELDS-1:0]   CFG      = '0,
    parameter logic [N_FIELDS-1:0]     MAP      = '1
) (
    input  logic [N_FIELDS-1:0] bits_i,
    input  logic [N_FIELDS-1:0] inv_gate_i,
    input  logic [N_FIELDS-1:0] true_gate_i,
    output logic                any_o
);

    logic [N_FIELDS-1:0] term;

    always_comb begin
        for (int i = 0; i < N_FIELDS; i++) begin
            unique case (qual_kind_e'(CFG[2*i +: 2]))
                QK_INVERT: term[i] = bits_i[i] & ~inv_gate_i[i];
                QK_TRUE:   term[i] = bits_i[i] &  true_gate_i[i];
                default:   term[i] = bits_i[i];
            endcase
            term[i] = term[i] & MAP[i];
        end
    end

    assign any_o = |term;

endmodule

// File: rtl/intreg_halt_agg.sv
`timescale 1ns/1ps
module intreg_halt_agg
    import intreg_pkg::*;
#(
    parameter int                    N_FIELDS = 10,
    parameter logic [N_FIELDS-1:0]   INTR_MAP = 10'h1FF,
    parameter logic [2*N_FIELDS-1:0] QUAL_CFG = 20'd411940,
    parameter logic [2*N_FIELDS-1:0] HALT_CFG = 20'd435520
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_FIELDS-1:0] evt_i,
    input  logic                clr_we_i,
    input  logic [N_FIELDS-1:0] clr_data_i,
    input  logic [N_FIELDS-1:0] mask_i,
    input  logic [N_FIELDS-1:0] enable_i,
    input  logic [N_FIELDS-1:0] hmask_i,
    input  logic [N_FIELDS-1:0] henable_i,
    output logic [N_FIELDS-1:0] field_q_o,
    output logic                intr_o,
    output logic                halt_o
);

    function automatic logic halt_wanted();
        logic found = 1'b0;
        for (int i = 0; i < N_FIELDS; i++) begin
            if (INTR_MAP[i] && (HALT_CFG[2*i +: 2] == QK_INVERT ||
                                HALT_CFG[2*i +: 2] == QK_TRUE))
                found = 1'b1;
        end
        return found;
    endfunction

    localparam logic HALT_PRESENT = halt_wanted();

    logic [N_FIELDS-1:0] flag_q;
    logic [N_FIELDS-1:0] ack_req;
    logic                intr_any;
    logic                halt_any;

    assign ack_req = clr_data_i & {N_FIELDS{clr_we_i}};

    generate
        for (genvar g = 0; g < N_FIELDS; g++) begin : g_flag
            intreg_field_bit u_bit (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (evt_i[g]),
                .clr_i (ack_req[g]),
                .q_o   (flag_q[g])
            );
        end
    endgenerate

    intreg_or_agg #(
        .N_FIELDS (N_FIELDS),
        .CFG      (QUAL_CFG),
        .MAP      (INTR_MAP)
    ) u_intr_or (
        .bits_i      (flag_q),
        .inv_gate_i  (mask_i),
        .true_gate_i (enable_i),
        .any_o       (intr_any)
    );

    intreg_or_agg #(
        .N_FIELDS (N_FIELDS),
        .CFG      (HALT_CFG),
        .MAP      (INTR_MAP)
    ) u_halt_or (
        .bits_i      (flag_q),
        .inv_gate_i  (hmask_i),
        .true_gate_i (henable_i),
        .any_o       (halt_any)
    );

    assign field_q_o = flag_q;
    assign intr_o    = intr_any;
    assign halt_o    = HALT_PRESENT & halt_any;

    AST_INTR_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        intr_o |-> |(field_q_o & INTR_MAP)); // R11

    AST_HALT_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> |(field_q_o & INTR_MAP)); // R10

endmodule

// File: tb/sim_intreg_halt_agg.sv
`timescale 1ns/1ps
module sim_intreg_halt_agg;

    localparam int          N   = 10;
    localparam logic [9:0]  MAP = 10'h1FF;
    localparam logic [19:0] QC  = 20'd411940;
    localparam logic [19:0] HC  = 20'd435520;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] evt = '0, clr_data = '0, mask = '0, en = '0, hmask = '0, hen = '0;
    logic clr_we = 1'b0;
    logic [N-1:0] fq;
    logic intr, halt;
    logic [3:0] fq1;
    logic intr1, halt1;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;

    intreg_halt_agg #(.N_FIELDS(N), .INTR_MAP(MAP), .QUAL_CFG(QC), .HALT_CFG(HC)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_we_i(clr_we), .clr_data_i(clr_data),
        .mask_i(mask), .enable_i(en), .hmask_i(hmask), .henable_i(hen),
        .field_q_o(fq), .intr_o(intr), .halt_o(halt));

    intreg_halt_agg #(.N_FIELDS(4), .INTR_MAP(4'hF), .QUAL_CFG(8'h24), .HALT_CFG(8'h00)) u1 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt[3:0]), .clr_we_i(clr_we), .clr_data_i(clr_data[3:0]),
        .mask_i(mask[3:0]), .enable_i(en[3:0]), .hmask_i(hmask[3:0]), .henable_i(hen[3:0]),
        .field_q_o(fq1), .intr_o(intr1), .halt_o(halt1));

    // Behavioural reference flags.
    logic [N-1:0] mq;
    logic [3:0]   mq1;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mq  <= '0;
            mq1 <= '0;
        end else begin
            mq  <= evt | (mq & ~(clr_we ? clr_data : '0));
            mq1 <= evt[3:0] | (mq1 & ~(clr_we ? clr_data[3:0] : 4'h0));
        end
    end

    function automatic bit gated_or(input logic [31:0] q, inv, tru, input logic [63:0] cfg,
                                     input logic [31:0] imap, input int n);
        bit r = 0;
        for (int i = 0; i < n; i++) begin
            int code = int'(cfg[2*i +: 2]);
            if (imap[i]) begin
                if (code == 1)      r |= q[i] & ~inv[i];
                else if (code == 2) r |= q[i] & tru[i];
                else                r |= q[i];
            end
        end
        return r;
    endfunction

    function automatic bit halt_on(input logic [63:0] cfg, input logic [31:0] imap, input int n);
        bit r = 0;
        for (int i = 0; i < n; i++) begin
            int code = int'(cfg[2*i +: 2]);
            if (imap[i] && (code == 1 || code == 2)) r = 1;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the reference, away from the edges.
    always @(negedge clk) begin
        #5;
        if (cmp_on && rst_n) begin
            chk("R2,R3,R4 flags", 32'(fq), 32'(mq));
            chk("R8 intr", 32'(intr), 32'(gated_or(32'(mq), 32'(mask), 32'(en), 64'(QC), 32'(MAP), N)));
            chk("R9 halt", 32'(halt), 32'(halt_on(64'(HC), 32'(MAP), N) &
                gated_or(32'(mq), 32'(hmask), 32'(hen), 64'(HC), 32'(MAP), N)));
            chk("R12 halt absent", 32'(halt1), 32'd0);
            chk("R8 intr second", 32'(intr1), 32'(gated_or(32'(mq1), 32'(mask[3:0]), 32'(en[3:0]), 64'h24, 32'hF, 4)));
        end
    end

    task automatic pulse(input int idx);
        @(negedge clk);
        evt = N'(1) << idx;
        @(negedge clk);
        evt = '0;
        #1;
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_we = 1'b1;
        clr_data = '1;
        @(negedge clk);
        clr_we = 1'b0;
        clr_data = '0;
        #1;
    endtask

    task automatic step_gate();
        @(negedge clk);
    endtask

    initial begin
        #1;
        chk("R1 flags in reset", 32'(fq), 0);
        chk("R1 intr in reset", 32'(intr), 0);
        chk("R1 halt in reset", 32'(halt), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // mask-gated field 1, halt ungated
        pulse(1);
        chk("R2 set", 32'(fq), 32'h002);
        chk("R5 mask low passes", 32'(intr), 1);
        chk("R10 raw halt", 32'(halt), 1);
        step_gate(); mask[1] = 1'b1; #1;
        chk("R5 mask high blocks", 32'(intr), 0);
        chk("R10 halt ignores mask", 32'(halt), 1);
        step_gate(); clr_we = 1'b1; clr_data = 10'h002;
        step_gate(); clr_we = 1'b0; clr_data = '0; #1;
        chk("R3 clear", 32'(fq), 0);

        // enable-gated field 2; clear data without strobe
        pulse(2);
        step_gate(); clr_data = '1;
        step_gate(); clr_data = '0; #1;
        chk("R3 no strobe no effect", 32'(fq), 32'h004);
        chk("R6 enable low blocks", 32'(intr), 0);
        step_gate(); en[2] = 1'b1; #1;
        chk("R6 enable high passes", 32'(intr), 1);
        chk("R10 raw halt field 2", 32'(halt), 1);
        clear_all();
        en = '0;

        // ungated field 0
        step_gate(); mask = '1;
        pulse(0);
        chk("R7 direct ignores gates", 32'(intr), 1);
        clear_all();
        mask = '0;

        // field 3: direct interrupt, inverted halt gate
        pulse(3);
        chk("R9 halt mask low passes", 32'(halt), 1);
        step_gate(); hmask[3] = 1'b1; #1;
        chk("R9 halt mask high blocks", 32'(halt), 0);
        chk("R7 direct intr", 32'(intr), 1);
        clear_all();
        hmask = '0;

        // field 6: true halt gate
        pulse(6);
        chk("R9 halt enable low blocks", 32'(halt), 0);
        step_gate(); hen[6] = 1'b1; #1;
        chk("R9 halt enable high passes", 32'(halt), 1);
        clear_all();
        hen = '0;

        // simultaneous set and clear
        @(negedge clk);
        evt = 10'h010; clr_we = 1'b1; clr_data = '1;
        @(negedge clk);
        evt = '0; clr_we = 1'b0; clr_data = '0; #1;
        chk("R4 set beats clear", 32'(fq), 32'h010);
        clear_all();

        // status-only field 9
        step_gate(); mask = '0; en = '1; hmask = '0; hen = '1;
        pulse(9);
        chk("R11 status bit stored", 32'(fq), 32'h200);
        chk("R11 no intr", 32'(intr), 0);
        chk("R11 no halt", 32'(halt), 0);
        clear_all();
        en = '0; hen = '0;

        // second instance without halt gates
        @(negedge clk); evt = 10'h00F;
        @(negedge clk); evt = '0; hmask = '0; hen = '1; #1;
        chk("R12 second flags", 32'(fq1), 32'hF);
        chk("R12 halt stays low", 32'(halt1), 0);
        clear_all();

        // random traffic
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            evt      = N'($urandom & $urandom & $urandom);
            clr_we   = 1'($urandom);
            clr_data = N'($urandom);
            mask     = N'($urandom);
            en       = N'($urandom);
            hmask    = N'($urandom);
            hen      = N'($urandom);
        end
        @(negedge clk);
        #6;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule